// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the single control and status word shared by every channel of a multi-channel DMA controller. It holds a master enable and two sticky error flags. The first flag records that a channel reported a bad address. The second records that a non-maskable interrupt arrived. The block merges these three bits with each channel's own enable and transfer-end bits and drives one transfer-permit line per channel. The channel engines use that line to decide whether they may start or continue a transfer.

Software reaches the register through a one-word interface with a read strobe, a write strobe, write data and read data. The hardware event inputs set the flags. A flag cannot be set by software. Software can clear a flag only through a handshake: it must first read the flag as 1, and its next write must then carry 0 in that bit. Any write between the read and the clearing write cancels the handshake. Two resets clear the whole word: an asynchronous power-on reset and a synchronous manual reset.

Top module: `dma_gcsr`

## Requirements
- R1: After power-on reset, all three bits read as 0 and every channel permit is 0.
- R2: A one-cycle pulse on `addr_err_i` sets the address-error flag (bit 2) on that clock edge. The flag then reads as 1.
- R3: A pulse on `nmi_i` sets the NMI flag (bit 1). This happens whether or not any channel currently holds a permit, and that permit drops on the same edge.
- R4: A CPU write of 1 to bit 2 or bit 1 does not change that flag.
- R5: A flag clears only when a write carries 0 in its bit and the last access to the register before that write was a read that returned 1 in that bit. A write of 0 with no such read leaves the flag set.
- R6: Any write cancels a pending read-as-1 handshake. A read of 1, then a write of 1 to that bit, then a write of 0 leaves the flag set.
- R7: If a set event and a qualifying clear write happen in the same cycle, the flag stays 1.
- R8: Bit 0 is the master enable. It can be read and written freely.
- R9: Channel i's permit is 1 only when the master enable is 1, `ch_en_i[i]` is 1, `ch_te_i[i]` is 0, and both flags are 0.
- R10: Writing 0 to the master enable drops every permit on the clock edge of that write.
- R11: A manual reset pulse clears all three bits and the handshake state on the next edge.
- R12: Read data bits above bit 2 are always 0, and writes to those bits have no effect. Read data is 0 while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| man_rst_i | input | 1 | Synchronous manual reset, active high |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe |
| wdata_i | input | DW | CPU write data |
| rdata_o | output | DW | CPU read data (bit 2 address error, bit 1 NMI, bit 0 master enable) |
| addr_err_i | input | 1 | Address-error event pulse |
| nmi_i | input | 1 | NMI event pulse |
| ch_en_i | input | NCH | Per-channel enable bits |
| ch_te_i | input | NCH | Per-channel transfer-end bits |
| ch_permit_o | output | NCH | Per-channel transfer permit |

## Verification
A wrong value in a flag or in the master enable shows on the permit lines on the very next clock edge, because the permits are combinational from those bits. A flag that is wrongly set forces every permit low. A flag that is wrongly clear lets enabled channels run.

A wrong handshake state cannot be seen directly. It shows only on the read that follows a clearing write: either a flag that should have stayed set reads as 0, or a flag that should have cleared still reads as 1. For this reason the bench always follows a clearing write with a read, and it checks the permits in the cycle right after each write.

// File: rtl/dma_gcsr_pkg.sv
package dma_gcsr_pkg;
  localparam int unsigned BIT_ME  = 0;
  localparam int unsigned BIT_NMI = 1;
  localparam int unsigned BIT_AE  = 2;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned USED_BITS = 3;

  typedef struct packed {
    logic ae;
    logic nmi;
    logic me;
  } gcsr_bits_t;
endpackage

// File: rtl/dma_gcsr_flag.sv
// Sticky flag: hardware set, read-1-then-write-0 clear
module dma_gcsr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic man_rst_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, arm_q;
  logic clr_ok;

  assign clr_ok = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (man_rst_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // set has priority over a qualifying clear
      if (set_i)       flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      // any write cancels the handshake
      if (wr_i)                arm_q <= 1'b0;
      else if (rd_i && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/dma_gcsr_men.sv
module dma_gcsr_men (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic man_rst_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic me_o
);
  logic me_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        me_q <= 1'b0;
    else if (man_rst_i) me_q <= 1'b0;
    else if (wr_i)      me_q <= wbit_i;
  end

  assign me_o = me_q;
endmodule

// File: rtl/dma_gcsr_gate.sv
module dma_gcsr_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic           me_i,
  input  logic           ae_i,
  input  logic           nmi_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] ch_te_i,
  output logic [NCH-1:0] permit_o
);
  logic glb_ok;
  assign glb_ok = me_i && !ae_i && !nmi_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign permit_o[g] = glb_ok && ch_en_i[g] && !ch_te_i[g];
  end
endmodule

// File: rtl/dma_gcsr.sv
module dma_gcsr
  import dma_gcsr_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           man_rst_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           addr_err_i,
  input  logic           nmi_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] ch_te_i,
  output logic [NCH-1:0] ch_permit_o
);
  localparam int unsigned PAD_W = DW - USED_BITS;

  logic [NUM_FLAGS-1:0] flag_set, flag_q, flag_arm, flag_wbit;
  logic       me_q;
  logic       ae_q, nmi_q, ae_arm, nmi_arm;
  gcsr_bits_t rd_bits;

  // flag index 0 = NMI (bit 1), index 1 = address error (bit 2)
  assign flag_set  = {addr_err_i, nmi_i};
  assign flag_wbit = {wdata_i[BIT_AE], wdata_i[BIT_NMI]};

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    dma_gcsr_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .man_rst_i (man_rst_i),
      .set_i     (flag_set[f]),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .wbit_i    (flag_wbit[f]),
      .flag_o    (flag_q[f]),
      .armed_o   (flag_arm[f])
    );
  end

  assign nmi_q   = flag_q[0];
  assign ae_q    = flag_q[1];
  assign nmi_arm = flag_arm[0];
  assign ae_arm  = flag_arm[1];

  dma_gcsr_men u_men (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .man_rst_i (man_rst_i),
    .wr_i      (wr_i),
    .wbit_i    (wdata_i[BIT_ME]),
    .me_o      (me_q)
  );

  dma_gcsr_gate #(.NCH(NCH)) u_gate (
    .me_i     (me_q),
    .ae_i     (ae_q),
    .nmi_i    (nmi_q),
    .ch_en_i  (ch_en_i),
    .ch_te_i  (ch_te_i),
    .permit_o (ch_permit_o)
  );

  assign rd_bits = '{ae: ae_q, nmi: nmi_q, me: me_q};
  assign rdata_o = rd_i ? {{PAD_W{1'b0}}, rd_bits} : '0;
endmodule

// File: rtl/dma_gcsr_chk.sv
module dma_gcsr_chk #(
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           man_rst_i,
  input logic           rd_i,
  input logic           wr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [DW-1:0]  rdata_o,
  input logic           addr_err_i,
  input logic           nmi_i,
  input logic [NCH-1:0] ch_permit_o,
  input logic           ae_q,
  input logic           nmi_q,
  input logic           me_q,
  input logic           ae_arm,
  input logic           nmi_arm
);
  p_ae_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_i && !man_rst_i |=> ae_q);

  p_nmi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i && !man_rst_i |=> nmi_q);

  p_no_cpu_set_ae_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ae_q) |-> $past(addr_err_i));

  p_no_cpu_set_nmi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_q) |-> $past(nmi_i));

  p_ae_clear_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ae_q) |-> ($past(man_rst_i) || $past(wr_i && !wdata_i[2] && ae_arm)));

  p_nmi_clear_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_q) |-> ($past(man_rst_i) || $past(wr_i && !wdata_i[1] && nmi_arm)));

  p_permit_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_permit_o) |-> (me_q && !ae_q && !nmi_q));

  p_me_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !me_q |-> (ch_permit_o == '0));

  p_man_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> (!ae_q && !nmi_q && !me_q));

  p_upper_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:3] == '0);
endmodule

bind dma_gcsr dma_gcsr_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .man_rst_i   (man_rst_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .addr_err_i  (addr_err_i),
  .nmi_i       (nmi_i),
  .ch_permit_o (ch_permit_o),
  .ae_q        (ae_q),
  .nmi_q       (nmi_q),
  .me_q        (me_q),
  .ae_arm      (ae_arm),
  .nmi_arm     (nmi_arm)
);

// File: tb/dma_gcsr_tb_top.sv
module dma_gcsr_tb_top;
  localparam int unsigned DW  = 32;
  localparam int unsigned NCH = 4;

  // {me, en[3:0], te[3:0], expected permit[3:0]}
  localparam int NVEC = 8;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 4'hF, 4'h0, 4'hF},
    {1'b1, 4'hF, 4'hF, 4'h0},
    {1'b1, 4'hA, 4'h2, 4'h8},
    {1'b0, 4'hF, 4'h0, 4'h0},
    {1'b1, 4'h5, 4'h4, 4'h1},
    {1'b1, 4'h3, 4'hC, 4'h3},
    {1'b0, 4'hA, 4'h0, 4'h0},
    {1'b1, 4'hC, 4'h8, 4'h4}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           man_rst_i = 1'b0;
  logic           rd_i = 1'b0;
  logic           wr_i = 1'b0;
  logic [DW-1:0]  wdata_i = '0;
  logic [DW-1:0]  rdata_o;
  logic           addr_err_i = 1'b0;
  logic           nmi_i = 1'b0;
  logic [NCH-1:0] ch_en_i = '0;
  logic [NCH-1:0] ch_te_i = '0;
  logic [NCH-1:0] ch_permit_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  dma_gcsr #(.DW(DW), .NCH(NCH)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .man_rst_i   (man_rst_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .addr_err_i  (addr_err_i),
    .nmi_i       (nmi_i),
    .ch_en_i     (ch_en_i),
    .ch_te_i     (ch_te_i),
    .ch_permit_o (ch_permit_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic do_read(input string req, input logic [2:0] exp);
    @(negedge clk_i);
    rd_i = 1'b1;
    #1 chk(req, rdata_o, {29'd0, exp});
    @(negedge clk_i);
    rd_i = 1'b0;
    #1 chk({req, " idle"}, rdata_o, '0);
  endtask

  task automatic pulse_ae();
    @(negedge clk_i); addr_err_i = 1'b1;
    @(negedge clk_i); addr_err_i = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk_i); nmi_i = 1'b1;
    @(negedge clk_i); nmi_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    ch_en_i = 4'hF;
    @(negedge clk_i);
    chk("R1 permit", {28'd0, ch_permit_o}, '0);
    do_read("R1 reset value", 3'b000);

    // R8 R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      ch_en_i = VEC[i][11:8];
      ch_te_i = VEC[i][7:4];
      do_write({31'd0, VEC[i][12]});
      chk("R9 permit vector", {28'd0, ch_permit_o}, {28'd0, VEC[i][3:0]});
    end
    do_read("R8 me readback", 3'b001);
    do_write('0);
    do_read("R8 me cleared", 3'b000);
    ch_te_i = '0;

    // R4 writes of 1 ignored
    do_write(32'h0000_0006);
    do_read("R4 no cpu set", 3'b000);

    // R2 set, R5 write 0 without prior read
    pulse_ae();
    do_write('0);
    do_read("R5 no clear without read", 3'b100);
    do_write('0);
    do_read("R5 clear after read", 3'b000);

    // R6 intervening write cancels handshake
    pulse_nmi();
    do_read("R3 nmi set", 3'b010);
    do_write(32'h0000_0002);
    do_write('0);
    do_read("R6 handshake cancelled", 3'b010);
    do_write('0);
    do_read("R6 clear after new read", 3'b000);

    // R3 nmi blocks running channels, R9 clear reopens
    ch_en_i = 4'hF;
    do_write(32'h0000_0001);
    chk("R9 permit open", {28'd0, ch_permit_o}, 32'hF);
    pulse_nmi();
    chk("R3 nmi drops permit", {28'd0, ch_permit_o}, '0);
    do_read("R3 nmi while active", 3'b011);
    do_write(32'h0000_0001);
    chk("R9 permit after nmi clear", {28'd0, ch_permit_o}, 32'hF);

    // R2 address error blocks all channels
    pulse_ae();
    chk("R9 ae drops permit", {28'd0, ch_permit_o}, '0);
    do_read("R2 ae set", 3'b101);
    // R7 set wins over clear in same cycle
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = 32'h1; addr_err_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0; addr_err_i = 1'b0;
    do_read("R7 set wins", 3'b101);
    do_write(32'h0000_0001);
    do_read("R5 ae cleared", 3'b001);
    chk("R9 permit restored", {28'd0, ch_permit_o}, 32'hF);

    // R10 clearing me stops all channels
    do_write('0);
    chk("R10 me off stops", {28'd0, ch_permit_o}, '0);

    // R12 upper bits
    do_write(32'hFFFF_FFF9);
    do_read("R12 upper bits", 3'b001);
    chk("R12 upper write no flag", {28'd0, ch_permit_o}, 32'hF);

    // R11 manual reset
    pulse_ae();
    pulse_nmi();
    @(negedge clk_i); man_rst_i = 1'b1;
    @(negedge clk_i); man_rst_i = 1'b0;
    chk("R11 permit after manual reset", {28'd0, ch_permit_o}, '0);
    do_read("R11 manual reset value", 3'b000);

    finish_run();
  end
endmodule